// File: doc/BRIEF.md
# Multifunction Pin Drive Controller

This block controls a single configurable I/O pad. A role register chooses what the pin does: it can be switched off, used as a general output driven from a value register, carry an interrupt level, carry a clock, or act as an input. A separate drive-style register sets how a logic 0 and a logic 1 reach the pad. Each level can be driven strongly, supplied through a weak on-chip pull, or left floating. The pad controls come out as data, output enable, pull-up enable and pull-down enable, ready for an analog pad cell.

In input mode, the pad level passes through a synchronizer and is held in a monitor register, where the rest of the chip can read it. The role, drive-style and value registers each have their own write strobe. The pad control outputs follow the registers and the routed interrupt and clock levels through combinational logic.

Top module: `mfpin_ctrl`

## Requirements
- R1: After reset the role is off (code 0), the drive style is 010, the output value is 0 and the monitor reads 0. With the role off, pad_out, pad_oe, pad_pu and pad_pd are all 0.
- R2: Role codes are 0 off, 1 general output, 2 interrupt, 3 clock and 4 input. When the role is off, input, or an unused code from 5 to 7, pad_oe, pad_pu, pad_pd and pad_out are all 0 whatever the drive style or level.
- R3: In the three output roles, drive style 000 and the reserved styles 110 and 111 leave the pad floating: oe, pu and pd are all 0.
- R4: Drive style 001 drives both levels strongly: oe=1 and pad_out equals the level.
- R5: Drive style 010 drives a 0 strongly (oe=1, pad_out=0) and gives a 1 through the pull-up only (oe=0, pu=1).
- R6: Drive style 011 drives a 0 strongly and floats for a 1 (oe=0, no pulls).
- R7: Drive style 100 gives a 0 through the pull-down only (oe=0, pd=1) and drives a 1 strongly.
- R8: Drive style 101 floats for a 0 and drives a 1 strongly.
- R9: In general-output role, the level comes from the value register, which is loaded by val_wr_en at a clock edge.
- R10: In interrupt role the level is irq_lvl, and in clock role the level is clkout_lvl. Neither the value register nor the other source has any effect.
- R11: In input role, mon_level equals pad_in as sampled three rising edges earlier: two synchronizer flops, then the monitor register.
- R12: When the role is not input, mon_level is 0 after the next rising edge.
- R13: Pull-up and pull-down are never enabled together, and neither is enabled while the output enable is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| func_wr_en | input | 1 | Write strobe for the role register |
| func_wr_data | input | 3 | New role code |
| drv_wr_en | input | 1 | Write strobe for the drive-style register |
| drv_wr_data | input | 3 | New drive-style code |
| val_wr_en | input | 1 | Write strobe for the output value register |
| val_wr_data | input | 1 | New output value |
| irq_lvl | input | 1 | Interrupt level routed to the pin in interrupt role |
| clkout_lvl | input | 1 | Clock level routed to the pin in clock role |
| pad_in | input | 1 | Asynchronous level seen at the pad |
| pad_out | output | 1 | Data toward the pad driver |
| pad_oe | output | 1 | Strong driver enable |
| pad_pu | output | 1 | Weak pull-up enable |
| pad_pd | output | 1 | Weak pull-down enable |
| mon_level | output | 1 | Synchronized pad level in input role |

## Verification
The assertions check on every cycle that the pulls never conflict with each other or with the strong driver, and that nothing leaves the block in the non-driving roles or the floating styles. They also check that each pull appears only under its own style and level, that general-output data tracks the value register, and that the monitor stage either follows the synchronizer or clears. Only the bench scenarios can show that every role, style and level combination yields the exact pad vector, that the wrong source is never picked, that reset defaults hold, and that the full three-edge monitor latency applies to a changing pad pattern.

// File: rtl/mfpin_pkg.sv
package mfpin_pkg;

  localparam int FN_W  = 3;
  localparam int DRV_W = 3;

  localparam logic [FN_W-1:0] FN_OFF = 3'd0;
  localparam logic [FN_W-1:0] FN_GPO = 3'd1;
  localparam logic [FN_W-1:0] FN_IRQ = 3'd2;
  localparam logic [FN_W-1:0] FN_CLK = 3'd3;
  localparam logic [FN_W-1:0] FN_GPI = 3'd4;

  localparam logic [DRV_W-1:0] DS_FLOAT   = 3'b000;
  localparam logic [DRV_W-1:0] DS_PUSH    = 3'b001;
  localparam logic [DRV_W-1:0] DS_LO_PU   = 3'b010;
  localparam logic [DRV_W-1:0] DS_LO_ONLY = 3'b011;
  localparam logic [DRV_W-1:0] DS_PD_HI   = 3'b100;
  localparam logic [DRV_W-1:0] DS_HI_ONLY = 3'b101;

  typedef struct packed {
    logic dat;
    logic oe;
    logic pu;
    logic pd;
  } pad_ctl_t;

  localparam pad_ctl_t PAD_IDLE = '{dat: 1'b0, oe: 1'b0, pu: 1'b0, pd: 1'b0};

  // True for roles that put a level on the pin
  function automatic logic fn_is_output(input logic [FN_W-1:0] fn);
    return (fn == FN_GPO) || (fn == FN_IRQ) || (fn == FN_CLK);
  endfunction

  // Map a drive style and a logic level onto pad controls
  function automatic pad_ctl_t drive_map(input logic [DRV_W-1:0] style, input logic lvl);
    pad_ctl_t p;
    p = PAD_IDLE;
    unique case (style)
      DS_PUSH: begin
        p.oe  = 1'b1;
        p.dat = lvl;
      end
      DS_LO_PU: begin
        p.oe = ~lvl;
        p.pu = lvl;
      end
      DS_LO_ONLY: p.oe = ~lvl;
      DS_PD_HI: begin
        p.oe  = lvl;
        p.dat = lvl;
        p.pd  = ~lvl;
      end
      DS_HI_ONLY: begin
        p.oe  = lvl;
        p.dat = lvl;
      end
      default: p = PAD_IDLE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/mfpin_cfg_regs.sv
module mfpin_cfg_regs
  import mfpin_pkg::*;
#(
  parameter logic [FN_W-1:0]  RST_FN  = FN_OFF,
  parameter logic [DRV_W-1:0] RST_DRV = DS_LO_PU
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fn_we,
  input  logic [FN_W-1:0]  fn_wd,
  input  logic             drv_we,
  input  logic [DRV_W-1:0] drv_wd,
  input  logic             val_we,
  input  logic             val_wd,
  output logic [FN_W-1:0]  fn_q,
  output logic [DRV_W-1:0] drv_q,
  output logic             val_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q  <= RST_FN;
      drv_q <= RST_DRV;
      val_q <= 1'b0;
    end else begin
      if (fn_we)  fn_q  <= fn_wd;
      if (drv_we) drv_q <= drv_wd;
      if (val_we) val_q <= val_wd;
    end
  end

endmodule

// File: rtl/mfpin_src_mux.sv
module mfpin_src_mux
  import mfpin_pkg::*;
(
  input  logic [FN_W-1:0] fn,
  input  logic            val_q,
  input  logic            irq_lvl,
  input  logic            clk_lvl,
  output logic            lvl,
  output logic            active
);

  always_comb begin
    lvl = 1'b0;
    unique case (fn)
      FN_GPO:  lvl = val_q;
      FN_IRQ:  lvl = irq_lvl;
      FN_CLK:  lvl = clk_lvl;
      default: lvl = 1'b0;
    endcase
  end

  assign active = fn_is_output(fn);

endmodule

// File: rtl/mfpin_drive_enc.sv
module mfpin_drive_enc
  import mfpin_pkg::*;
(
  input  logic [DRV_W-1:0] style,
  input  logic             lvl,
  input  logic             active,
  output pad_ctl_t         ctl
);

  pad_ctl_t mapped;

  always_comb begin
    mapped = drive_map(style, lvl);
    ctl    = active ? mapped : PAD_IDLE;
  end

endmodule

// File: rtl/mfpin_sync_mon.sv
module mfpin_sync_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_in,
  input  logic capture,
  output logic sync_lvl,
  output logic mon_q
);

  logic [SYNC_STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pad_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_lvl = chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mon_q <= 1'b0;
    else if (capture) mon_q <= sync_lvl;
    else              mon_q <= 1'b0;
  end

endmodule

// File: rtl/mfpin_ctrl.sv
module mfpin_ctrl
  import mfpin_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [DRV_W-1:0] RST_DRV     = DS_LO_PU
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             func_wr_en,
  input  logic [FN_W-1:0]  func_wr_data,
  input  logic             drv_wr_en,
  input  logic [DRV_W-1:0] drv_wr_data,
  input  logic             val_wr_en,
  input  logic             val_wr_data,
  input  logic             irq_lvl,
  input  logic             clkout_lvl,
  input  logic             pad_in,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             pad_pu,
  output logic             pad_pd,
  output logic             mon_level
);

  logic [FN_W-1:0]  fn_q;
  logic [DRV_W-1:0] drv_q;
  logic             val_q;
  logic             sel_lvl;
  logic             drv_active;
  logic             sync_lvl;
  logic             in_mode;
  pad_ctl_t         ctl;

  mfpin_cfg_regs #(
    .RST_FN  (FN_OFF),
    .RST_DRV (RST_DRV)
  ) cfg_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .fn_we  (func_wr_en),
    .fn_wd  (func_wr_data),
    .drv_we (drv_wr_en),
    .drv_wd (drv_wr_data),
    .val_we (val_wr_en),
    .val_wd (val_wr_data),
    .fn_q   (fn_q),
    .drv_q  (drv_q),
    .val_q  (val_q)
  );

  mfpin_src_mux mux_i (
    .fn      (fn_q),
    .val_q   (val_q),
    .irq_lvl (irq_lvl),
    .clk_lvl (clkout_lvl),
    .lvl     (sel_lvl),
    .active  (drv_active)
  );

  mfpin_drive_enc enc_i (
    .style  (drv_q),
    .lvl    (sel_lvl),
    .active (drv_active),
    .ctl    (ctl)
  );

  assign in_mode = (fn_q == FN_GPI);

  mfpin_sync_mon #(
    .SYNC_STAGES (SYNC_STAGES)
  ) mon_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .capture  (in_mode),
    .sync_lvl (sync_lvl),
    .mon_q    (mon_level)
  );

  assign pad_out = ctl.dat;
  assign pad_oe  = ctl.oe;
  assign pad_pu  = ctl.pu;
  assign pad_pd  = ctl.pd;

endmodule

// File: rtl/mfpin_ctrl_chk.sv
module mfpin_ctrl_chk
  import mfpin_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [FN_W-1:0]  fn_q,
  input logic [DRV_W-1:0] drv_q,
  input logic             val_q,
  input logic             sel_lvl,
  input logic             sync_lvl,
  input logic             pad_out,
  input logic             pad_oe,
  input logic             pad_pu,
  input logic             pad_pd,
  input logic             mon_level
);

  logic out_role;
  assign out_role = (fn_q == FN_GPO) || (fn_q == FN_IRQ) || (fn_q == FN_CLK);

  a_r2_quiet_roles: assert property (@(posedge clk) disable iff (!rst_n)
    !out_role |-> (!pad_oe && !pad_pu && !pad_pd && !pad_out));

  a_r3_float_styles: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_q == 3'b000 || drv_q == 3'b110 || drv_q == 3'b111) |-> (!pad_oe && !pad_pu && !pad_pd));

  a_r5_pullup_src: assert property (@(posedge clk) disable iff (!rst_n)
    pad_pu |-> (drv_q == 3'b010 && sel_lvl && out_role));

  a_r7_pulldown_src: assert property (@(posedge clk) disable iff (!rst_n)
    pad_pd |-> (drv_q == 3'b100 && !sel_lvl && out_role));

  a_r9_gpo_value: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_q == FN_GPO && pad_oe) |-> (pad_out == val_q));

  a_r11_mon_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_q == FN_GPI) |=> (mon_level == $past(sync_lvl)));

  a_r12_mon_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_q != FN_GPI) |=> !mon_level);

  a_r13_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
    !(pad_pu && pad_pd) && !(pad_oe && (pad_pu || pad_pd)));

endmodule

bind mfpin_ctrl mfpin_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .fn_q      (fn_q),
  .drv_q     (drv_q),
  .val_q     (val_q),
  .sel_lvl   (sel_lvl),
  .sync_lvl  (sync_lvl),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pad_pu    (pad_pu),
  .pad_pd    (pad_pd),
  .mon_level (mon_level)
);

// File: tb/mfpin_ctrl_tb_top.sv
module mfpin_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       func_wr_en = 1'b0;
  logic [2:0] func_wr_data = 3'd0;
  logic       drv_wr_en = 1'b0;
  logic [2:0] drv_wr_data = 3'd0;
  logic       val_wr_en = 1'b0;
  logic       val_wr_data = 1'b0;
  logic       irq_lvl = 1'b0;
  logic       clkout_lvl = 1'b0;
  logic       pad_in = 1'b0;
  logic       pad_out, pad_oe, pad_pu, pad_pd, mon_level;

  int n_run = 0;
  int n_fail = 0;
  logic pat [0:47];

  always #4 clk = ~clk;

  mfpin_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .func_wr_en   (func_wr_en),
    .func_wr_data (func_wr_data),
    .drv_wr_en    (drv_wr_en),
    .drv_wr_data  (drv_wr_data),
    .val_wr_en    (val_wr_en),
    .val_wr_data  (val_wr_data),
    .irq_lvl      (irq_lvl),
    .clkout_lvl   (clkout_lvl),
    .pad_in       (pad_in),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .pad_pu       (pad_pu),
    .pad_pd       (pad_pd),
    .mon_level    (mon_level)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Expected {dat,oe,pu,pd}, written by level rather than by style
  function automatic logic [3:0] expect_pad(input int fn, input int ds, input logic l);
    logic oe, pu, pd;
    oe = 1'b0; pu = 1'b0; pd = 1'b0;
    if (fn >= 1 && fn <= 3) begin
      if (l == 1'b0) begin
        oe = (ds == 1) || (ds == 2) || (ds == 3);
        pd = (ds == 4);
      end else begin
        oe = (ds == 1) || (ds == 4) || (ds == 5);
        pu = (ds == 2);
      end
    end
    return {oe & l, oe, pu, pd};
  endfunction

  function automatic string req_of(input int fn, input int ds);
    if (fn == 0 || fn >= 4) return "R2";
    case (ds)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic set_cfg(input int fn, input int ds);
    @(negedge clk);
    func_wr_en = 1'b1; func_wr_data = fn[2:0];
    drv_wr_en  = 1'b1; drv_wr_data  = ds[2:0];
    @(negedge clk);
    func_wr_en = 1'b0; drv_wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: reset state, role off
    check("R1 pads after reset", {pad_out, pad_oe, pad_pu, pad_pd}, 4'b0000);
    check("R1 monitor after reset", {3'b0, mon_level}, 4'b0000);
    // R1: reset drive style 010 seen by writing only the role
    @(negedge clk);
    func_wr_en = 1'b1; func_wr_data = 3'd1;
    @(negedge clk);
    func_wr_en = 1'b0;
    check("R1 default style, value reset 0", {pad_out, pad_oe, pad_pu, pad_pd}, 4'b0100);
    @(negedge clk);
    val_wr_en = 1'b1; val_wr_data = 1'b1;
    @(negedge clk);
    val_wr_en = 1'b0;
    check("R1 default style level 1", {pad_out, pad_oe, pad_pu, pad_pd}, 4'b0010);

    // R2-R10: sweep every role, style and level; the other sources take the opposite level
    for (int fn = 0; fn < 8; fn++) begin
      for (int ds = 0; ds < 8; ds++) begin
        set_cfg(fn, ds);
        for (int l = 0; l < 2; l++) begin
          logic lv;
          lv = l[0];
          @(negedge clk);
          val_wr_en   = 1'b1;
          val_wr_data = (fn == 1) ? lv : ~lv;
          irq_lvl     = (fn == 2) ? lv : ~lv;
          clkout_lvl  = (fn == 3) ? lv : ~lv;
          @(negedge clk);
          val_wr_en = 1'b0;
          check(fn == 1 ? "R9 value reg source" : fn == 2 ? "R10 irq source" :
                fn == 3 ? "R10 clock source" : req_of(fn, ds),
                {pad_out, pad_oe, pad_pu, pad_pd}, expect_pad(fn, ds, lv));
          check(req_of(fn, ds), {pad_out, pad_oe, pad_pu, pad_pd}, expect_pad(fn, ds, lv));
          // R13: no pull alongside the driver, never both pulls
          check("R13 no conflict", {2'b0, (pad_pu & pad_pd), (pad_oe & (pad_pu | pad_pd))}, 4'b0000);
        end
      end
    end

    // R11: input role, monitor three edges behind pad_in
    set_cfg(4, 1);
    for (int i = 0; i < 48; i++) pat[i] = ((i * 7 + i / 3) % 5) < 2;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk) pad_in = pat[i];
      @(posedge clk); #1;
      if (i >= 2) check("R11 monitor latency", {3'b0, mon_level}, {3'b0, pat[i-2]});
      check("R11 pad not driven in input role", {pad_out, pad_oe, pad_pu, pad_pd}, 4'b0000);
    end

    // R12: leave input role with pad high; monitor clears
    @(negedge clk) pad_in = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R11 monitor high", {3'b0, mon_level}, 4'b0001);
    @(negedge clk);
    func_wr_en = 1'b1; func_wr_data = 3'd1;
    @(negedge clk);
    func_wr_en = 1'b0;
    @(posedge clk); #1;
    check("R12 monitor cleared outside input role", {3'b0, mon_level}, 4'b0000);
    repeat (3) @(posedge clk);
    #1 check("R12 monitor stays 0", {3'b0, mon_level}, 4'b0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule